// File: doc/BRIEF.md
# Character Input Device Register Interface

This block is the register front end of a slow character input device on a 16-bit memory-mapped bus. It answers at two even byte addresses: a combined control/status word and a data buffer word. Software starts a read by setting the go bit of the control/status word. The device returns one character with the number of the unit that produced it. Software then either polls the done bit by masking the status word with 0x80, or waits for an interrupt.

The status word keeps bit 15 as the OR of the specific error bits. A word with any error set therefore reads as a negative two's-complement number. Bus writes reach only the control bits. The status bits follow their own set and clear rules: starting an operation, a character arriving, an error pulse, and software reading the data buffer. The interrupt request is active low and is a plain level that follows the enabled completion and error condition.

Top module: `char_input_csr`

## Requirements
- R1: The control/status word answers at byte address octal 777560 and the data buffer at octal 777562. A read of any other address, odd addresses included, returns 0, and a write to any other address changes nothing.
- R2: The control/status word reads as follows: bit 15 error summary, bits 14..12 specific errors, bit 11 busy, bits 10..8 unit number, bit 7 done, bit 6 interrupt enable, bits 5..4 zero, bits 3..1 function code, bit 0 zero.
- R3: A write to the control/status word stores bit 6 and bits 3..1. Bits 15..7 of the written value are ignored.
- R4: Writing the control/status word with bit 0 set sets busy, clears done and all error bits, and raises dev_start for exactly the next cycle.
- R5: A cycle with dev_valid high loads dev_char into data buffer bits 7..0 (bits 15..8 read 0), latches dev_unit into the unit field, clears busy and sets done.
- R6: A bus read of the data buffer clears done from the next cycle on, unless a character arrives in the same cycle, in which case done stays set.
- R7: Each high bit of dev_err sets the matching sticky error bit (dev_err[0] to bit 12) and clears busy. Bit 15 reads 1 exactly when any of bits 14..12 is 1.
- R8: Busy and done are never both set. When a start write and a character arrival fall in the same cycle, the start wins the flags (busy 1, done 0), and the buffer still loads.
- R9: irq_n is low exactly while interrupt enable is set and done or any error bit is set. It goes high again when that condition clears.
- R10: After reset every status and control bit reads 0, the buffer reads 0, irq_n is high and dev_start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 18 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word, 0 if unmatched |
| dev_valid | input | 1 | One-cycle strobe: a character is delivered |
| dev_char | input | 8 | Delivered character |
| dev_unit | input | 3 | Unit that delivered the character |
| dev_err | input | 3 | Error pulses, one per specific error bit |
| dev_start | output | 1 | One-cycle pulse that starts the device |
| dev_func | output | 3 | Stored function code |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Directed sequences try a plain start, a character arrival and a buffer read. These separate the three flag transitions. Sequences that also set bits 15..7 in the write data show whether status bits can be written from the bus. Cycles in which a start lands on a character arrival, or a buffer read lands on an arrival, expose which of two competing updates wins. A seeded random mix of writes, arrivals, error pulses, reads and stray addresses is compared against a reference model of the flags. Status words with an error set are checked to read negative, and irq_n is checked against interrupt enable after every cycle.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int WORD_W  = 16;
  localparam int BIT_ERR = 15;
  localparam int ERR_LO  = 12;
  localparam int BIT_BSY = 11;
  localparam int UNIT_LO = 8;
  localparam int BIT_DON = 7;
  localparam int BIT_IE  = 6;
  localparam int FUNC_LO = 1;
  localparam int BIT_GO  = 0;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int          ADDR_W   = 18,
  parameter logic [17:0] CSR_ADDR = 18'o777560
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              csr_hit,
  output logic              buf_hit
);
  localparam logic [ADDR_W-1:0] BUF_ADDR = ADDR_W'(CSR_ADDR) + ADDR_W'(2);

  always_comb begin
    csr_hit = sel && (addr == ADDR_W'(CSR_ADDR));
    buf_hit = sel && (addr == BUF_ADDR);
  end
endmodule

// File: rtl/csr_ctrl_state.sv
module csr_ctrl_state #(
  parameter int FUNC_W = 3,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              wr_ie,
  input  logic [FUNC_W-1:0] wr_func,
  input  logic              go,
  input  logic              dev_valid,
  input  logic [ERR_W-1:0]  dev_err,
  input  logic              buf_rd,
  output logic              busy,
  output logic              done,
  output logic              ie,
  output logic [FUNC_W-1:0] func,
  output logic [ERR_W-1:0]  err,
  output logic              start
);
  logic              busy_d, done_d, ie_d, start_d;
  logic [FUNC_W-1:0] func_d;
  logic [ERR_W-1:0]  err_d;

  always_comb begin
    busy_d  = busy;
    done_d  = done;
    ie_d    = ie;
    func_d  = func;
    err_d   = err | dev_err;
    start_d = go;
    if (csr_wr) begin
      ie_d   = wr_ie;
      func_d = wr_func;
    end
    if (go) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      err_d  = '0;
    end else begin
      if (dev_valid || (|dev_err)) busy_d = 1'b0;
      if (dev_valid)               done_d = 1'b1;
      else if (buf_rd)             done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ie    <= 1'b0;
      func  <= '0;
      err   <= '0;
      start <= 1'b0;
    end else begin
      busy  <= busy_d;
      done  <= done_d;
      ie    <= ie_d;
      func  <= func_d;
      err   <= err_d;
      start <= start_d;
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8
  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && !done && err == '0 && start)); // R4
  AST_CHAR_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !go) |=> (done && !busy)); // R5
  AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !dev_valid && !go) |=> !done); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_err) && !go) |=> (((err & $past(dev_err)) == $past(dev_err)) && !busy)); // R7
endmodule

// File: rtl/csr_rx_buf.sv
module csr_rx_buf #(
  parameter int CHAR_W = 8,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_in,
  input  logic [UNIT_W-1:0] unit_in,
  output logic [CHAR_W-1:0] char_q,
  output logic [UNIT_W-1:0] unit_q
);
  logic [CHAR_W-1:0] char_d;
  logic [UNIT_W-1:0] unit_d;

  always_comb begin
    char_d = char_q;
    unit_d = unit_q;
    if (load) begin
      char_d = char_in;
      unit_d = unit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      unit_q <= '0;
    end else begin
      char_q <= char_d;
      unit_q <= unit_d;
    end
  end

  AST_BUF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (char_q == $past(char_in) && unit_q == $past(unit_in))); // R5
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(char_q)); // R5
endmodule

// File: rtl/char_input_csr.sv
module char_input_csr #(
  parameter int          ADDR_W   = 18,
  parameter logic [17:0] CSR_ADDR = 18'o777560,
  parameter int          CHAR_W   = 8,
  parameter int          UNIT_W   = 3,
  parameter int          FUNC_W   = 3,
  parameter int          ERR_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [csr_pkg::WORD_W-1:0] bus_wdata,
  output logic [csr_pkg::WORD_W-1:0] bus_rdata,
  input  logic                      dev_valid,
  input  logic [CHAR_W-1:0]         dev_char,
  input  logic [UNIT_W-1:0]         dev_unit,
  input  logic [ERR_W-1:0]          dev_err,
  output logic                      dev_start,
  output logic [FUNC_W-1:0]         dev_func,
  output logic                      irq_n
);
  import csr_pkg::*;

  logic              rst_m, rst_s;
  logic              csr_hit, buf_hit, csr_wr, buf_rd, go;
  logic              busy, done, ie;
  logic [FUNC_W-1:0] func;
  logic [ERR_W-1:0]  err;
  logic [CHAR_W-1:0] char_q;
  logic [UNIT_W-1:0] unit_q;
  logic [WORD_W-1:0] csr_word, buf_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  csr_addr_dec #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
    .sel(bus_sel), .addr(bus_addr), .csr_hit(csr_hit), .buf_hit(buf_hit));

  always_comb begin
    csr_wr = csr_hit && bus_wr;
    buf_rd = buf_hit && !bus_wr;
    go     = csr_wr && bus_wdata[BIT_GO];
  end

  csr_ctrl_state #(.FUNC_W(FUNC_W), .ERR_W(ERR_W)) u_state (
    .clk(clk), .rst_n(rst_s), .csr_wr(csr_wr), .wr_ie(bus_wdata[BIT_IE]),
    .wr_func(bus_wdata[FUNC_LO +: FUNC_W]), .go(go), .dev_valid(dev_valid),
    .dev_err(dev_err), .buf_rd(buf_rd), .busy(busy), .done(done), .ie(ie),
    .func(func), .err(err), .start(dev_start));

  csr_rx_buf #(.CHAR_W(CHAR_W), .UNIT_W(UNIT_W)) u_buf (
    .clk(clk), .rst_n(rst_s), .load(dev_valid), .char_in(dev_char),
    .unit_in(dev_unit), .char_q(char_q), .unit_q(unit_q));

  always_comb begin
    csr_word                      = '0;
    csr_word[BIT_ERR]             = |err;
    csr_word[ERR_LO +: ERR_W]     = err;
    csr_word[BIT_BSY]             = busy;
    csr_word[UNIT_LO +: UNIT_W]   = unit_q;
    csr_word[BIT_DON]             = done;
    csr_word[BIT_IE]              = ie;
    csr_word[FUNC_LO +: FUNC_W]   = func;
    buf_word                      = '0;
    buf_word[CHAR_W-1:0]          = char_q;
    if (csr_hit && !bus_wr)  bus_rdata = csr_word;
    else if (buf_rd)         bus_rdata = buf_word;
    else                     bus_rdata = '0;
    dev_func = func;
    irq_n    = !(ie && (done || (|err)));
  end

  AST_IRQ_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_s)
    (dev_valid && ie && !csr_wr) |=> !irq_n); // R9
  AST_IRQ_OFF_NO_IE: assert property (@(posedge clk) disable iff (!rst_s)
    (csr_wr && !bus_wdata[BIT_IE]) |=> irq_n); // R9
  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && bus_addr[0]) |-> (bus_rdata == '0)); // R1
endmodule

// File: tb/char_input_csr_test.sv
module char_input_csr_test;
  localparam logic [17:0] A_CSR = 18'o777560;
  localparam logic [17:0] A_BUF = 18'o777562;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dev_valid = 1'b0;
  logic [7:0]  dev_char = '0;
  logic [2:0]  dev_unit = '0, dev_err = '0;
  logic        dev_start;
  logic [2:0]  dev_func;
  logic        irq_n;

  int total = 0, bad = 0;

  // reference model
  logic       m_busy, m_done, m_ie, m_start;
  logic [2:0] m_func, m_err, m_unit;
  logic [7:0] m_char;

  always #4 clk = ~clk;

  char_input_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_valid(dev_valid), .dev_char(dev_char), .dev_unit(dev_unit),
    .dev_err(dev_err), .dev_start(dev_start), .dev_func(dev_func),
    .irq_n(irq_n));

  function automatic logic [15:0] exp_csr();
    return {|m_err, m_err, m_busy, m_unit, m_done, m_ie, 2'b00, m_func, 1'b0};
  endfunction

  function automatic logic exp_irq_n();
    return !(m_ie && (m_done || (|m_err)));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_done = 0; m_ie = 0; m_start = 0;
    m_func = 0; m_err = 0; m_unit = 0; m_char = 0;
  endtask

  // One bus/device cycle; returns read data sampled before the edge.
  task automatic step(input logic sel, input logic wr, input logic [17:0] a,
                      input logic [15:0] wd, input logic v, input logic [7:0] c,
                      input logic [2:0] u, input logic [2:0] e,
                      output logic [15:0] rd);
    logic go, brd;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    dev_valid = v; dev_char = c; dev_unit = u; dev_err = e;
    #2;
    rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; dev_valid = 0; dev_err = 0;
    go  = sel && wr && (a == A_CSR) && wd[0];
    brd = sel && !wr && (a == A_BUF);
    if (sel && wr && a == A_CSR) begin m_ie = wd[6]; m_func = wd[3:1]; end
    if (v) begin m_char = c; m_unit = u; end
    m_err = m_err | e;
    if (go) begin m_busy = 1; m_done = 0; m_err = 0; end
    else begin
      if (v || (|e)) m_busy = 0;
      if (v) m_done = 1; else if (brd) m_done = 0;
    end
    m_start = go;
    check("R9 irq_n", {15'd0, irq_n}, {15'd0, exp_irq_n()});
    check("R4 dev_start", {15'd0, dev_start}, {15'd0, m_start});
    check("R8 busy/done exclusive", {15'd0, m_busy && m_done}, 16'd0);
    #2;
  endtask

  task automatic wr_csr(input logic [15:0] d);
    logic [15:0] r;
    step(1, 1, A_CSR, d, 0, 0, 0, 0, r);
  endtask

  task automatic rd_chk(input logic [17:0] a, input string req);
    logic [15:0] r, e;
    e = (a == A_CSR) ? exp_csr() : (a == A_BUF) ? {8'd0, m_char} : 16'd0;
    step(1, 0, a, 0, 0, 0, 0, 0, r);
    check(req, r, e);
  endtask

  task automatic deliver(input logic [7:0] c, input logic [2:0] u);
    logic [15:0] r;
    step(0, 0, 0, 0, 1, c, u, 0, r);
  endtask

  initial begin
    #1_600_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 irq_n after reset", {15'd0, irq_n}, 16'd1);
    check("R10 dev_start after reset", {15'd0, dev_start}, 16'd0);
    rd_chk(A_CSR, "R10 csr after reset");
    rd_chk(A_BUF, "R10 buf after reset");

    // R3: status bits not writable, control bits stored
    wr_csr(16'hFF8E);
    rd_chk(A_CSR, "R3 write ignores 15..7");
    check("R3 dev_func", {13'd0, dev_func}, 16'd7);
    wr_csr(16'h0000);

    // R4 start via 0x41
    wr_csr(16'h0041);
    rd_chk(A_CSR, "R4 start sets busy");
    check("R4 busy bit", {15'd0, bus_rdata[11]}, 16'd0); // bus idle reads 0 (R1)
    // R5 arrival
    deliver(8'h5A, 3'd5);
    rd_chk(A_CSR, "R5 done set unit latched");
    check("R9 irq asserted on done", {15'd0, irq_n}, 16'd0);
    step(1, 0, A_CSR, 0, 0, 0, 0, 0, r);
    check("R2 done mask 0x80", r & 16'h0080, 16'h0080);
    rd_chk(A_BUF, "R5/R6 buffer read");
    rd_chk(A_CSR, "R6 done cleared by buffer read");
    check("R9 irq released", {15'd0, irq_n}, 16'd1);

    // R6: read and arrival same cycle
    step(1, 0, A_BUF, 0, 1, 8'hC3, 3'd2, 0, r);
    rd_chk(A_CSR, "R6 arrival wins over read");

    // R8: start and arrival same cycle
    step(1, 1, A_CSR, 16'h0041, 1, 8'h11, 3'd1, 0, r);
    rd_chk(A_CSR, "R8 start wins flags");
    rd_chk(A_BUF, "R8 buffer still loads");

    // R7 errors
    step(0, 0, 0, 0, 0, 0, 0, 3'b010, r);
    step(1, 0, A_CSR, 0, 0, 0, 0, 0, r);
    check("R7 error reads negative", {15'd0, r[15]}, 16'd1);
    check("R7 csr with error", r, exp_csr());
    step(0, 0, 0, 0, 0, 0, 0, 3'b100, r);
    rd_chk(A_CSR, "R7 errors sticky");
    wr_csr(16'h0041);
    rd_chk(A_CSR, "R4 start clears errors");

    // R1 stray addresses
    step(1, 1, A_CSR + 18'd1, 16'h0041, 0, 0, 0, 0, r);
    rd_chk(A_CSR, "R1 odd address write ignored");
    rd_chk(A_CSR + 18'd1, "R1 odd address read zero");
    rd_chk(18'o777564, "R1 other address read zero");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [17:0] a;
      op = $urandom_range(0, 7);
      case ($urandom_range(0, 3))
        0: a = A_CSR;
        1: a = A_BUF;
        2: a = A_CSR + 18'd1;
        default: a = 18'($urandom);
      endcase
      case (op)
        0, 1: step(1, 1, a, 16'($urandom), $urandom_range(0, 4) == 0,
                   8'($urandom), 3'($urandom), 0, r);
        2: step(0, 0, 0, 0, 1, 8'($urandom), 3'($urandom), 0, r);
        3: step(0, 0, 0, 0, $urandom_range(0, 1) == 1, 8'($urandom),
                3'($urandom), 3'($urandom), r);
        4: rd_chk(A_BUF, "R6 random buffer read");
        5: rd_chk(a, "R1 random address read");
        default: rd_chk(A_CSR, "R2 random csr read");
      endcase
    end
    rd_chk(A_CSR, "R2 final csr");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule